// File: doc/BRIEF.md
# Channel Address Interleave Reducer

This block takes a system address that has already been steered to one memory controller and one of its channels, and turns it into the address seen by that channel alone. It searches a small table of target ranges for the first entry that holds the address. It subtracts the offset that the matching entry stores for the selected channel. It then removes two levels of interleaving, across sockets and across channels. Each level divides the address bits above a chosen granularity bit by the number of ways and puts the bits below that granularity bit back in place.

Software loads the table through a simple write port: a range-base word, a range-limit/ways word and a per-channel offset word for each entry. The requester raises `start` for one cycle with an address and a channel index, and waits for the one-cycle `done` strobe. `done` carries either the reduced address and the two way counts, or a miss flag. Division by 1, 2, 4 or 8 is a shift. Division by 3 runs on a shared bit-serial restoring divider, so a request that interleaves three ways takes about `ADDR_W` more cycles.

Top module: `chan_addr_reducer`

## Requirements
- R1: A table entry covers the addresses from its base (base-word bits 31:12 shifted left by 26) up to its limit (limit-word bits 31:12 shifted left by 26, with the low 26 bits all ones), both ends included. When several entries cover the address, the one with the lowest index is used.
- R2: When no entry covers the address, `done` pulses with `miss` high, and `chan_addr`, `skt_ways` and `chn_ways` read zero.
- R3: On a hit, `skt_ways` equals 1 shifted left by limit-word bits 11:10, and `chn_ways` equals limit-word bits 9:8 plus one.
- R4: Base-word bits 5:4 hold the socket granularity code and bits 7:6 hold the channel granularity code. Codes 0, 1, 2 and 3 select granularity bit 6, 8, 12 and 30.
- R5: The offset word of the matched entry for channel `chan_idx` supplies bits 23:4, shifted left by 26. This offset is subtracted from the system address before interleave removal.
- R6: Apart from the case in R7, the socket level is removed first and the channel level second. Each level computes ((a >> g) / ways) << g and fills the low g bits from the original system address.
- R7: When channel ways is 3 and the socket granularity bit is above the channel granularity bit, the channel level is removed first and the socket level second. Each level fills its low g bits from its own input.
- R8: Division by three yields the exact floor quotient, including for dividends that are not multiples of three.
- R9: `busy` rises in the cycle after an accepted `start` and stays high until `done`. `done` is high for exactly one cycle. `chan_addr` does not change while the block is idle.
- R10: A `start` that arrives while `busy` is high is ignored. The running request completes with its own result, and no extra `done` follows.
- R11: Reset clears the table to zero and drives `busy`, `done`, `miss` and `chan_addr` low. A zeroed table maps only the lowest 64 MiB, with one way at each level.
- R12: A write with `cfg_we` high and `cfg_sel` 0 loads the base word, with `cfg_sel` 1 loads the limit/ways word, and with `cfg_sel` 2 loads the offset word of channel `cfg_chan`. Each write goes to entry `cfg_entry`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cfg_we | input | 1 | Table write strobe |
| cfg_sel | input | 2 | Word select: 0 base, 1 limit/ways, 2 channel offset |
| cfg_entry | input | ENT_W (3) | Table entry written |
| cfg_chan | input | CH_W (2) | Channel of an offset write |
| cfg_wdata | input | 32 | Write data |
| start | input | 1 | Request strobe |
| sys_addr | input | ADDR_W (46) | System address |
| chan_idx | input | CH_W (2) | Channel the address was routed to |
| busy | output | 1 | Request in progress |
| done | output | 1 | One-cycle completion strobe |
| miss | output | 1 | No entry matched, valid with done |
| chan_addr | output | ADDR_W (46) | Channel-local address |
| skt_ways | output | 4 | Socket way count of the matched entry |
| chn_ways | output | 3 | Channel way count of the matched entry |

## Verification
Most internal faults would show in the one `chan_addr` value returned with `done`. These include a wrong priority choice, a swapped granularity code, a wrong offset channel, a reversed step order or a bad low-bit source. A divider that drops or miscounts one iteration gives a quotient off by a factor of two or by one at the same strobe. The checks therefore use addresses whose digits differ in each field, so that such faults change the result. A sequencer that takes a second start or loses a step shows up as a wrong result, a missing `done`, or an extra `done` within the following tens of cycles.

// File: rtl/chan_addr_reducer.sv
module chan_addr_reducer #(
  parameter int ADDR_W   = 46,
  parameter int NUM_ENT  = 8,
  parameter int NUM_CHAN = 3,
  localparam int ENT_W   = (NUM_ENT  > 1) ? $clog2(NUM_ENT)  : 1,
  localparam int CH_W    = (NUM_CHAN > 1) ? $clog2(NUM_CHAN) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [1:0]        cfg_sel,
  input  logic [ENT_W-1:0]  cfg_entry,
  input  logic [CH_W-1:0]   cfg_chan,
  input  logic [31:0]       cfg_wdata,
  input  logic              start,
  input  logic [ADDR_W-1:0] sys_addr,
  input  logic [CH_W-1:0]   chan_idx,
  output logic              busy,
  output logic              done,
  output logic              miss,
  output logic [ADDR_W-1:0] chan_addr,
  output logic [3:0]        skt_ways,
  output logic [2:0]        chn_ways
);
  localparam int FLD_LSB = 26;
  localparam int CNT_W   = $clog2(ADDR_W + 1);

  typedef enum logic [1:0] {ST_IDLE, ST_LOOK, ST_STEP, ST_DIV} st_t;

  function automatic logic [4:0] gran_pos(input logic [1:0] code);
    case (code)
      2'd0:    return 5'd6;
      2'd1:    return 5'd8;
      2'd2:    return 5'd12;
      default: return 5'd30;
    endcase
  endfunction

  logic [19:0] base_f [NUM_ENT];
  logic [19:0] lim_f  [NUM_ENT];
  logic [1:0]  sg_f   [NUM_ENT];
  logic [1:0]  cg_f   [NUM_ENT];
  logic [1:0]  sw_f   [NUM_ENT];
  logic [1:0]  cw_f   [NUM_ENT];
  logic [19:0] off_f  [NUM_ENT][NUM_CHAN];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int e = 0; e < NUM_ENT; e++) begin
        base_f[e] <= '0; lim_f[e] <= '0;
        sg_f[e] <= '0; cg_f[e] <= '0; sw_f[e] <= '0; cw_f[e] <= '0;
        for (int c = 0; c < NUM_CHAN; c++) off_f[e][c] <= '0;
      end
    end else if (cfg_we) begin
      case (cfg_sel)
        2'd0: begin
          base_f[cfg_entry] <= cfg_wdata[31:12];
          cg_f[cfg_entry]   <= cfg_wdata[7:6];
          sg_f[cfg_entry]   <= cfg_wdata[5:4];
        end
        2'd1: begin
          lim_f[cfg_entry] <= cfg_wdata[31:12];
          sw_f[cfg_entry]  <= cfg_wdata[11:10];
          cw_f[cfg_entry]  <= cfg_wdata[9:8];
        end
        2'd2: begin
          for (int c = 0; c < NUM_CHAN; c++)
            if (CH_W'(c) == cfg_chan) off_f[cfg_entry][c] <= cfg_wdata[23:4];
        end
        default: ;
      endcase
    end
  end

  st_t              st;
  logic [ADDR_W-1:0] orig, cur, div_q;
  logic [CH_W-1:0]   chan_r;
  logic [1:0]        sg_r, cg_r, sw_r, cw_r, div_r;
  logic              ord_cf, step;
  logic [CNT_W-1:0]  div_cnt;

  assign busy = (st != ST_IDLE);

  logic             hit;
  logic [ENT_W-1:0] hit_idx;
  always_comb begin
    hit = 1'b0;
    hit_idx = '0;
    for (int e = NUM_ENT - 1; e >= 0; e--) begin
      if (orig >= ADDR_W'({base_f[e], {FLD_LSB{1'b0}}}) &&
          orig <= ADDR_W'({lim_f[e], {FLD_LSB{1'b1}}})) begin
        hit = 1'b1;
        hit_idx = ENT_W'(e);
      end
    end
  end

  logic [19:0] off_sel;
  always_comb begin
    off_sel = '0;
    for (int c = 0; c < NUM_CHAN; c++)
      if (CH_W'(c) == chan_r) off_sel = off_f[hit_idx][c];
  end
  wire [ADDR_W-1:0] off_full = ADDR_W'({off_sel, {FLD_LSB{1'b0}}});

  wire       step_is_chn = ord_cf ? !step : step;
  wire [4:0] step_s      = step_is_chn ? gran_pos(cg_r) : gran_pos(sg_r);
  wire       step_three  = step_is_chn && (cw_r == 2'd2);
  wire [1:0] chn_lg      = (cw_r == 2'd3) ? 2'd2 : cw_r;
  wire [1:0] step_lg     = step_is_chn ? chn_lg : sw_r;

  wire [ADDR_W-1:0] q_sh     = cur >> step_s;
  wire [ADDR_W-1:0] low_mask = (ADDR_W'(1) << step_s) - ADDR_W'(1);
  wire [ADDR_W-1:0] low_src  = ord_cf ? cur : orig;
  wire [ADDR_W-1:0] quot     = (st == ST_DIV) ? div_q : (q_sh >> step_lg);
  wire [ADDR_W-1:0] step_res = (quot << step_s) | (low_src & low_mask);

  wire [2:0] rem3   = {div_r, div_q[ADDR_W-1]};
  wire       rem_ge = (rem3 >= 3'd3);
  wire [2:0] rem_n  = rem_ge ? (rem3 - 3'd3) : rem3;

  wire div_end = (st == ST_DIV) && (div_cnt == CNT_W'(ADDR_W));
  wire apply   = ((st == ST_STEP) && !step_three) || div_end;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= ST_IDLE; orig <= '0; cur <= '0; chan_r <= '0;
      sg_r <= '0; cg_r <= '0; sw_r <= '0; cw_r <= '0;
      ord_cf <= 1'b0; step <= 1'b0;
      div_q <= '0; div_r <= '0; div_cnt <= '0;
      done <= 1'b0; miss <= 1'b0; chan_addr <= '0;
      skt_ways <= '0; chn_ways <= '0;
    end else begin
      done <= 1'b0;
      miss <= 1'b0;
      case (st)
        ST_IDLE: if (start) begin
          orig <= sys_addr;
          chan_r <= chan_idx;
          st <= ST_LOOK;
        end
        ST_LOOK: if (!hit) begin
          done <= 1'b1; miss <= 1'b1; chan_addr <= '0;
          skt_ways <= '0; chn_ways <= '0;
          st <= ST_IDLE;
        end else begin
          cur  <= orig - off_full;
          sg_r <= sg_f[hit_idx]; cg_r <= cg_f[hit_idx];
          sw_r <= sw_f[hit_idx]; cw_r <= cw_f[hit_idx];
          ord_cf <= (cw_f[hit_idx] == 2'd2) &&
                    (gran_pos(sg_f[hit_idx]) > gran_pos(cg_f[hit_idx]));
          skt_ways <= 4'd1 << sw_f[hit_idx];
          chn_ways <= {1'b0, cw_f[hit_idx]} + 3'd1;
          step <= 1'b0;
          st <= ST_STEP;
        end
        ST_STEP: if (step_three) begin
          div_q <= q_sh; div_r <= '0; div_cnt <= '0;
          st <= ST_DIV;
        end
        ST_DIV: if (!div_end) begin
          div_q <= {div_q[ADDR_W-2:0], rem_ge};
          div_r <= rem_n[1:0];
          div_cnt <= div_cnt + CNT_W'(1);
        end
        default: st <= ST_IDLE;
      endcase
      if (apply) begin
        if (!step) begin
          cur <= step_res; step <= 1'b1; st <= ST_STEP;
        end else begin
          chan_addr <= step_res; done <= 1'b1; st <= ST_IDLE;
        end
      end
    end
  end

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done); // R9
  AST_BUSY_ON_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n) (start && !busy) |=> busy); // R9
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n) (!busy && $past(!busy)) |-> $stable(chan_addr)); // R9
  AST_MISS_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n) miss |-> (done && chan_addr == '0)); // R2
  AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n) (start && busy) |=> $stable(orig)); // R10
  AST_DIV_REM: assert property (@(posedge clk) disable iff (!rst_n) (st == ST_DIV) |-> (div_r < 2'd3)); // R8
  AST_WAYS_SHAPE: assert property (@(posedge clk) disable iff (!rst_n) (done && !miss) |-> ($countones(skt_ways) == 1 && chn_ways >= 3'd1 && chn_ways <= 3'd4)); // R3
endmodule

// File: tb/chan_addr_reducer_tb.sv
module chan_addr_reducer_tb;
  localparam int AW = 46;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_sel = '0;
  logic [2:0]  cfg_entry = '0;
  logic [1:0]  cfg_chan = '0;
  logic [31:0] cfg_wdata = '0;
  logic        start = 1'b0;
  logic [AW-1:0] sys_addr = '0;
  logic [1:0]  chan_idx = '0;
  logic        busy, done, miss;
  logic [AW-1:0] chan_addr;
  logic [3:0]  skt_ways;
  logic [2:0]  chn_ways;

  chan_addr_reducer u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_entry(cfg_entry), .cfg_chan(cfg_chan), .cfg_wdata(cfg_wdata),
    .start(start), .sys_addr(sys_addr), .chan_idx(chan_idx),
    .busy(busy), .done(done), .miss(miss), .chan_addr(chan_addr),
    .skt_ways(skt_ways), .chn_ways(chn_ways)
  );

  int checks = 0;
  int fails = 0;
  int cyc = 0;

  typedef struct packed {
    logic [AW-1:0] a;
    logic [1:0]    ch;
    logic [AW-1:0] e;
    logic          m;
    logic [3:0]    sw;
    logic [2:0]    cw;
  } vec_t;

  localparam vec_t VEC [10] = '{
    '{46'h0000_0123_4567, 2'd0, 46'h0000_0123_4567, 1'b0, 4'd1, 3'd1},
    '{46'h0000_0500_0ABC, 2'd0, 46'h0000_0040_02FC, 1'b0, 4'd2, 3'd2},
    '{46'h0000_0500_0ABC, 2'd1, 46'h0000_0140_02FC, 1'b0, 4'd2, 3'd2},
    '{46'h0000_1000_3FC5, 2'd0, 46'h0000_0000_0545, 1'b0, 4'd2, 3'd3},
    '{46'h0000_1000_0100, 2'd0, 46'h0000_0000_0040, 1'b0, 4'd2, 3'd3},
    '{46'h0000_2000_0C37, 2'd2, 46'h0000_0000_0437, 1'b0, 4'd1, 3'd3},
    '{46'h0003_C000_0011, 2'd0, 46'h0000_4000_0011, 1'b0, 4'd8, 3'd1},
    '{46'h0010_0000_5ABC, 2'd1, 46'h0004_0000_1ABC, 1'b0, 4'd1, 3'd4},
    '{46'h0000_3000_0000, 2'd0, 46'h0,              1'b1, 4'd0, 3'd0},
    '{46'h0020_0000_0000, 2'd0, 46'h0,              1'b1, 4'd0, 3'd0}
  };

  localparam string VREQ [10] = '{"R1", "R5 R6 R1", "R5 R6", "R7", "R8",
                                   "R6 R4", "R3 R4", "R3 R4", "R2", "R2"};

  logic [AW-1:0] r_addr;
  logic r_miss;
  logic [3:0] r_sw;
  logic [2:0] r_cw;

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic cfg_write(input logic [1:0] sel, input logic [2:0] ent,
                           input logic [1:0] ch, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = sel; cfg_entry = ent; cfg_chan = ch; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic run(input logic [AW-1:0] a, input logic [1:0] ch, input string req);
    int n;
    @(negedge clk);
    start = 1'b1; sys_addr = a; chan_idx = ch;
    @(negedge clk);
    start = 1'b0;
    check({req, " busy after start"}, 64'(busy), 64'd1);
    n = 0;
    while (!done && n < 200) begin
      @(negedge clk);
      n++;
    end
    check({req, " done seen"}, 64'(done), 64'd1);
    r_addr = chan_addr; r_miss = miss; r_sw = skt_ways; r_cw = chn_ways;
    @(negedge clk);
    check("R9 done one cycle", 64'(done), 64'd0);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected<100000", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R11 busy at reset", 64'(busy), 64'd0);
    check("R11 done at reset", 64'(done), 64'd0);
    check("R11 miss at reset", 64'(miss), 64'd0);
    check("R11 chan_addr at reset", 64'(chan_addr), 64'd0);
    rst_n = 1'b1;

    run(46'h0000_0400_0000, 2'd0, "R11");
    check("R11 empty table miss", 64'(r_miss), 64'd1);
    run(46'h0000_0000_0100, 2'd0, "R11");
    check("R11 empty table identity", 64'(r_addr), 64'h100);
    check("R11 empty table ways", {r_sw, r_cw}, {4'd1, 3'd1});

    cfg_write(2'd0, 3'd1, 2'd0, 32'h0000_1010);
    cfg_write(2'd1, 3'd1, 2'd0, 32'h0000_3500);
    cfg_write(2'd2, 3'd1, 2'd0, 32'h0000_0010);
    cfg_write(2'd0, 3'd2, 2'd0, 32'h0000_4020);
    cfg_write(2'd1, 3'd2, 2'd0, 32'h0000_7600);
    cfg_write(2'd2, 3'd2, 2'd0, 32'h0000_0040);
    cfg_write(2'd0, 3'd3, 2'd0, 32'h0000_8040);
    cfg_write(2'd1, 3'd3, 2'd0, 32'h0000_B200);
    cfg_write(2'd2, 3'd3, 2'd2, 32'h0000_0080);
    cfg_write(2'd0, 3'd4, 2'd0, 32'h0001_0030);
    cfg_write(2'd1, 3'd4, 2'd0, 32'h003F_FC00);
    cfg_write(2'd0, 3'd5, 2'd0, 32'h0000_1000);
    cfg_write(2'd1, 3'd5, 2'd0, 32'h0000_1000);
    cfg_write(2'd0, 3'd6, 2'd0, 32'h0040_0090);
    cfg_write(2'd1, 3'd6, 2'd0, 32'h0040_0300);

    // R12: entries loaded through all three word selects feed the table walk below
    for (int i = 0; i < 10; i++) begin
      run(VEC[i].a, VEC[i].ch, VREQ[i]);
      check({VREQ[i], " R12 chan_addr"}, 64'(r_addr), 64'(VEC[i].e));
      check({VREQ[i], " miss"}, 64'(r_miss), 64'(VEC[i].m));
      check({VREQ[i], " R3 ways"}, {r_sw, r_cw}, {VEC[i].sw, VEC[i].cw});
    end

    begin
      int n;
      int extra;
      @(negedge clk);
      start = 1'b1; sys_addr = 46'h0000_1000_3FC5; chan_idx = 2'd0;
      @(negedge clk);
      start = 1'b0;
      repeat (5) @(negedge clk);
      start = 1'b1; sys_addr = 46'h0000_0123_4567; chan_idx = 2'd1;
      @(negedge clk);
      start = 1'b0;
      n = 0;
      while (!done && n < 200) begin
        @(negedge clk);
        n++;
      end
      check("R10 result of first request", 64'(chan_addr), 64'h545);
      extra = 0;
      repeat (80) begin
        @(negedge clk);
        if (done) extra++;
      end
      check("R10 no second done", 64'(extra), 64'd0);
      check("R9 idle hold chan_addr", 64'(chan_addr), 64'h545);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule